// File: doc/BRIEF.md
# Platform-level external interrupt controller

This block collects level-sensitive interrupt requests from up to 53 peripheral sources. It forwards, to each processor hart, one interrupt line that reports whether a suitable request is waiting. Software sets up the block through a plain 32-bit register port with address, write data, read data, a read strobe and a write strobe. Each source has a 3-bit priority. Each hart has its own enable mask and its own priority threshold. A source is eligible for a hart when it is pending, enabled for that hart, and its priority is strictly above that hart's threshold. Among eligible sources the highest priority wins, and a tie goes to the lower source ID.

A hart takes an interrupt by reading its claim/complete register. The read returns the winning ID in the same cycle. At the following clock edge the source's pending bit clears and the source enters service. While a source is in service its request line cannot make it pending again. When the handler finishes, it writes the ID back to the same register. That completion releases the source, and the next cycle its level request can mark it pending again. Source ID 0 is reserved and means "nothing to take".

Top module: `ext_irq_ctrl`

## Requirements
- R1: ID 0 is reserved. Its pending bit (bit 0 of the word at 0x1000), its enable bit (bit 0 of every hart's first enable word) and its priority register (offset 0) always read 0, and writes to them have no effect.
- R2: The priority of source N (1..53) is at byte offset N*4. It stores bits [2:0] of the write data and reads back with bits [31:3] as zero. Offsets of nonexistent sources (54 and up) read 0.
- R3: Pending state reads from offsets 0x1000 (IDs 0..31, bit k = ID k) and 0x1004 (IDs 32..53 on bits 0..21). A source whose request is high and which is not in service becomes pending at the next clock edge. It stays pending after the request drops.
- R4: Hart h has two enable words at 0x2000 + h*0x80 (IDs 0..31) and 0x2000 + h*0x80 + 4 (IDs 32..53), with bit k meaning ID 32*word + k. The words read back as written for IDs 1..53 and read 0 elsewhere.
- R5: Hart h's threshold is at 0x200000 + h*0x1000, 3 bits wide. A source is presented only when its priority is strictly greater than the threshold. Priority 0 is never presented, and threshold 7 blocks every source.
- R6: Among eligible sources, the highest priority wins. Equal priorities go to the smaller ID.
- R7: Hart h's interrupt output is high, combinationally in the same cycle, exactly when at least one source is eligible for that hart.
- R8: A read of hart h's claim register at 0x200004 + h*0x1000 returns the winning ID in that cycle, or 0 when nothing is eligible. A nonzero return clears the source's pending bit and puts it in service at the next clock edge.
- R9: A source in service does not become pending again, whatever its request line does. A completion write of its ID releases it, and a request that is still high re-arms it on the edge after that.
- R10: A completion write with value 0, a value above 53, or the ID of a source not in service changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| src_req | input | 53 | Level requests; bit k is source ID k+1 |
| bus_addr | input | 24 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe; a claim read has its side effect at the next edge |
| bus_rdata | output | 32 | Read data, valid combinationally while the address is held |
| hart_irq | output | 2 | Interrupt line per hart |

## Verification
Several behaviours are checked by assertions on every cycle:
- A pending source is never also in service.
- A claim always moves its source from pending to in service.
- A valid completion always releases its source.
- The chosen winner is always pending, enabled and above the threshold.
- A threshold of 7 always keeps the line low.
- The interrupt line always agrees with the arbiter's result.

Other behaviours can only be shown by the bench scenarios, because they depend on what software wrote earlier or on the order of operations:
- the exact tie-break across the two pending words;
- the register address map;
- re-arming from a request line still held high after completion;
- invalid completions leaving the pending state untouched.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  // Register region selected by a bus address
  typedef enum logic [2:0] {
    RGN_NONE,
    RGN_PRIO,
    RGN_PEND,
    RGN_EN,
    RGN_THR,
    RGN_CLAIM
  } rgn_e;

  localparam int unsigned BUS_W      = 32;
  localparam logic [31:0] OFS_PEND   = 32'h0000_1000;
  localparam logic [31:0] OFS_EN     = 32'h0000_2000;
  localparam logic [31:0] EN_STRIDE  = 32'h0000_0080;
  localparam logic [31:0] OFS_CTX    = 32'h0020_0000;
  localparam logic [31:0] CTX_STRIDE = 32'h0000_1000;

endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
  import irqc_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int NUM_SRC  = 53,
  parameter int NUM_HART = 2,
  parameter int ID_W     = 6,
  parameter int HART_W   = 1,
  parameter int WORD_W   = 1
) (
  input  logic [ADDR_W-1:0] addr,
  output rgn_e              rgn,
  output logic [ID_W-1:0]   src,
  output logic [HART_W-1:0] hart,
  output logic [WORD_W-1:0] word
);

  localparam int NUM_WORDS = (NUM_SRC + 32) / 32;

  logic [31:0] a;
  logic [31:0] off;

  always_comb begin
    a   = '0;
    a[ADDR_W-1:0] = addr;
    off  = '0;
    rgn  = RGN_NONE;
    src  = '0;
    hart = '0;
    word = '0;
    if (a[1:0] == 2'b00) begin
      if (a < OFS_PEND) begin
        if (int'(a[11:2]) <= NUM_SRC) begin
          rgn = RGN_PRIO;
          src = ID_W'(a[11:2]);
        end
      end else if (a < OFS_PEND + 32'(NUM_WORDS * 4)) begin
        rgn  = RGN_PEND;
        word = WORD_W'(a[11:2]);
      end else if (a >= OFS_EN && a < OFS_EN + 32'(NUM_HART) * EN_STRIDE) begin
        off = a - OFS_EN;
        if (int'(off[6:0]) < NUM_WORDS * 4) begin
          rgn  = RGN_EN;
          hart = HART_W'(off >> 7);
          word = WORD_W'(off[6:2]);
        end
      end else if (a >= OFS_CTX && a < OFS_CTX + 32'(NUM_HART) * CTX_STRIDE) begin
        off  = a - OFS_CTX;
        hart = HART_W'(off >> 12);
        if (off[11:0] == 12'h000) begin
          rgn = RGN_THR;
        end else if (off[11:0] == 12'h004) begin
          rgn = RGN_CLAIM;
        end
      end
    end
  end

endmodule

// File: rtl/irqc_cfg.sv
module irqc_cfg #(
  parameter int NUM_SRC  = 53,
  parameter int NUM_HART = 2,
  parameter int PRIO_W   = 3,
  parameter int ID_W     = 6,
  parameter int HART_W   = 1,
  parameter int WORD_W   = 1
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 wr_prio,
  input  logic                                 wr_en,
  input  logic                                 wr_thr,
  input  logic [ID_W-1:0]                      src,
  input  logic [HART_W-1:0]                    hart,
  input  logic [WORD_W-1:0]                    word,
  input  logic [31:0]                          wdata,
  output logic [NUM_SRC:0][PRIO_W-1:0]         prio_q,
  output logic [NUM_HART-1:0][NUM_SRC:0]       en_q,
  output logic [NUM_HART-1:0][PRIO_W-1:0]      thr_q
);

  logic [NUM_SRC:0][PRIO_W-1:0]    prio_d;
  logic [NUM_HART-1:0][NUM_SRC:0]  en_d;
  logic [NUM_HART-1:0][PRIO_W-1:0] thr_d;
  logic                            cfg_ce;

  assign cfg_ce = wr_prio | wr_en | wr_thr;

  always_comb begin
    prio_d = prio_q;
    en_d   = en_q;
    thr_d  = thr_q;
    if (wr_prio && src != '0) begin
      prio_d[src] = wdata[PRIO_W-1:0];
    end
    if (wr_en) begin
      for (int b = 0; b < 32; b++) begin
        if (int'(word) * 32 + b >= 1 && int'(word) * 32 + b <= NUM_SRC) begin
          en_d[hart][int'(word) * 32 + b] = wdata[b];
        end
      end
    end
    if (wr_thr) begin
      thr_d[hart] = wdata[PRIO_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q <= '0;
      en_q   <= '0;
      thr_q  <= '0;
    end else if (cfg_ce) begin
      prio_q <= prio_d;
      en_q   <= en_d;
      thr_q  <= thr_d;
    end
  end

  // R2: a priority write to a real source is stored as its low bits
  assert_prio_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_prio && src != '0) |=> prio_q[$past(src)] == $past(wdata[PRIO_W-1:0]));

  // R5: a threshold write lands in the addressed hart only
  assert_thr_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_thr |=> thr_q[$past(hart)] == $past(wdata[PRIO_W-1:0]));

endmodule

// File: rtl/irqc_gateway.sv
module irqc_gateway #(
  parameter int NUM_SRC = 53,
  parameter int ID_W    = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC:1]   req,
  input  logic               claim_fire,
  input  logic [ID_W-1:0]    claim_id,
  input  logic               cmpl_fire,
  input  logic [ID_W-1:0]    cmpl_id,
  output logic [NUM_SRC:0]   pend_q,
  output logic [NUM_SRC:0]   insvc_q
);

  logic [NUM_SRC:0] pend_d;
  logic [NUM_SRC:0] insvc_d;
  logic             gw_ce;

  assign gw_ce = claim_fire | cmpl_fire | (|req);

  always_comb begin
    pend_d  = pend_q;
    insvc_d = insvc_q;
    for (int i = 1; i <= NUM_SRC; i++) begin
      if (req[i] && !insvc_q[i]) begin
        pend_d[i] = 1'b1;
      end
      if (claim_fire && int'(claim_id) == i) begin
        pend_d[i]  = 1'b0;
        insvc_d[i] = 1'b1;
      end
      if (cmpl_fire && int'(cmpl_id) == i) begin
        insvc_d[i] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      insvc_q <= '0;
    end else if (gw_ce) begin
      pend_q  <= pend_d;
      insvc_q <= insvc_d;
    end
  end

  // R9: a source in service is never pending at the same time
  assert_no_repend_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q & insvc_q) == '0);

  // R8: a claim moves its source from pending to in service
  assert_claim_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
    claim_fire |=> (insvc_q[$past(claim_id)] && !pend_q[$past(claim_id)]));

  // R9: a completion releases its source
  assert_cmpl_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_fire |=> !insvc_q[$past(cmpl_id)]);

  // R1: reserved ID never pending nor in service
  assert_id0_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q[0] && !insvc_q[0]);

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
  parameter int NUM_SRC = 53,
  parameter int PRIO_W  = 3,
  parameter int ID_W    = 6
) (
  input  logic [NUM_SRC:0]              pend,
  input  logic [NUM_SRC:0]              en,
  input  logic [NUM_SRC:0][PRIO_W-1:0]  prio,
  input  logic [PRIO_W-1:0]             thr,
  output logic [ID_W-1:0]               win_id,
  output logic                          irq
);

  logic [NUM_SRC:0]  elig;
  logic [PRIO_W-1:0] best_p;

  // Eligibility vector feeds the line; the scan below feeds the claim value
  always_comb begin
    for (int i = 0; i <= NUM_SRC; i++) begin
      elig[i] = pend[i] & en[i] & (prio[i] > thr);
    end
  end

  assign irq = |elig;

  // Ascending scan with strict compare: ties keep the lower ID
  always_comb begin
    best_p = thr;
    win_id = '0;
    for (int i = 0; i <= NUM_SRC; i++) begin
      if (pend[i] && en[i] && prio[i] > best_p) begin
        best_p = prio[i];
        win_id = ID_W'(i);
      end
    end
  end

endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int NUM_SRC  = 53,
  parameter int NUM_HART = 2,
  parameter int PRIO_W   = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   src_req,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  output logic [31:0]          bus_rdata,
  output logic [NUM_HART-1:0]  hart_irq
);

  localparam int ID_W      = $clog2(NUM_SRC + 1);
  localparam int HART_W    = (NUM_HART > 1) ? $clog2(NUM_HART) : 1;
  localparam int NUM_WORDS = (NUM_SRC + 32) / 32;
  localparam int WORD_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

  rgn_e                            rgn;
  logic [ID_W-1:0]                 dec_src;
  logic [HART_W-1:0]               dec_hart;
  logic [WORD_W-1:0]               dec_word;
  logic [NUM_SRC:0][PRIO_W-1:0]    prio_q;
  logic [NUM_HART-1:0][NUM_SRC:0]  en_q;
  logic [NUM_HART-1:0][PRIO_W-1:0] thr_q;
  logic [NUM_SRC:0]                pend_q;
  logic [NUM_SRC:0]                insvc_q;
  logic [NUM_HART-1:0][ID_W-1:0]   win_id;
  logic                            claim_fire;
  logic [ID_W-1:0]                 claim_id;
  logic                            cmpl_fire;
  logic [ID_W-1:0]                 cmpl_id;

  irqc_decode #(
    .ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC), .NUM_HART(NUM_HART),
    .ID_W(ID_W), .HART_W(HART_W), .WORD_W(WORD_W)
  ) u_decode (
    .addr(bus_addr), .rgn(rgn), .src(dec_src), .hart(dec_hart), .word(dec_word)
  );

  irqc_cfg #(
    .NUM_SRC(NUM_SRC), .NUM_HART(NUM_HART), .PRIO_W(PRIO_W),
    .ID_W(ID_W), .HART_W(HART_W), .WORD_W(WORD_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .wr_prio(bus_wr && rgn == RGN_PRIO),
    .wr_en(bus_wr && rgn == RGN_EN),
    .wr_thr(bus_wr && rgn == RGN_THR),
    .src(dec_src), .hart(dec_hart), .word(dec_word), .wdata(bus_wdata),
    .prio_q(prio_q), .en_q(en_q), .thr_q(thr_q)
  );

  // Claim: read of a claim register with a winner present
  assign claim_fire = bus_rd && rgn == RGN_CLAIM && win_id[dec_hart] != '0;
  assign claim_id   = win_id[dec_hart];

  // Completion: write of an ID inside 1..NUM_SRC; in-service check in gateway
  assign cmpl_fire = bus_wr && rgn == RGN_CLAIM &&
                     bus_wdata >= 32'd1 && bus_wdata <= 32'(NUM_SRC);
  assign cmpl_id   = bus_wdata[ID_W-1:0];

  irqc_gateway #(
    .NUM_SRC(NUM_SRC), .ID_W(ID_W)
  ) u_gateway (
    .clk(clk), .rst_n(rst_n), .req(src_req),
    .claim_fire(claim_fire), .claim_id(claim_id),
    .cmpl_fire(cmpl_fire), .cmpl_id(cmpl_id),
    .pend_q(pend_q), .insvc_q(insvc_q)
  );

  for (genvar h = 0; h < NUM_HART; h++) begin : g_hart
    irqc_arbiter #(
      .NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)
    ) u_arb (
      .pend(pend_q), .en(en_q[h]), .prio(prio_q), .thr(thr_q[h]),
      .win_id(win_id[h]), .irq(hart_irq[h])
    );

    // R5: the highest threshold keeps the line low
    assert_thr_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_q[h] == '1) |-> !hart_irq[h]);

    // R6: a chosen winner is pending, enabled and above threshold
    assert_winner_ok_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (win_id[h] != '0) |->
        (pend_q[win_id[h]] && en_q[h][win_id[h]] && prio_q[win_id[h]] > thr_q[h]));

    // R7: line agrees with the arbiter scan
    assert_irq_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
      hart_irq[h] == (win_id[h] != '0));
  end

  // Read data mux
  always_comb begin
    bus_rdata = '0;
    unique case (rgn)
      RGN_PRIO:  bus_rdata[PRIO_W-1:0] = prio_q[dec_src];
      RGN_PEND: begin
        for (int b = 0; b < 32; b++) begin
          if (int'(dec_word) * 32 + b <= NUM_SRC) begin
            bus_rdata[b] = pend_q[int'(dec_word) * 32 + b];
          end
        end
      end
      RGN_EN: begin
        for (int b = 0; b < 32; b++) begin
          if (int'(dec_word) * 32 + b <= NUM_SRC) begin
            bus_rdata[b] = en_q[dec_hart][int'(dec_word) * 32 + b];
          end
        end
      end
      RGN_THR:   bus_rdata[PRIO_W-1:0] = thr_q[dec_hart];
      RGN_CLAIM: bus_rdata[ID_W-1:0]   = win_id[dec_hart];
      default:   bus_rdata = '0;
    endcase
  end

  // R2: priority reads carry zeros above the stored field
  assert_prio_rd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && rgn == RGN_PRIO) |-> bus_rdata[31:PRIO_W] == '0);

  // R8: a claim with nothing eligible returns zero
  assert_empty_claim_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && rgn == RGN_CLAIM && !hart_irq[dec_hart]) |-> bus_rdata == '0);

endmodule

// File: tb/test_ext_irq_ctrl.sv
`timescale 1ns/1ps
module test_ext_irq_ctrl;

  localparam int NS = 53;
  localparam int NH = 2;
  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src_req = '0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [31:0]   bus_rdata;
  logic [NH-1:0] hart_irq;

  always #10 clk = ~clk;

  ext_irq_ctrl i_ext_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .hart_irq(hart_irq)
  );

  // Behavioural reference state
  int    m_prio [0:NS];
  bit    m_pend [0:NS];
  bit    m_isv  [0:NS];
  bit    m_en   [0:NH-1][0:NS];
  int    m_thr  [0:NH-1];
  int    vectors = 0;
  int    miscompares = 0;
  string tag = "R1";

  // kind: 0 none, 1 prio, 2 pend, 3 enable, 4 threshold, 5 claim
  function automatic void dec(input int a, output int kind, output int h, output int x);
    kind = 0; h = 0; x = 0;
    if (a % 4 != 0) return;
    if (a < 'h1000) begin
      if (a / 4 <= NS) begin kind = 1; x = a / 4; end
    end else if (a < 'h1008) begin
      kind = 2; x = (a - 'h1000) / 4;
    end else if (a >= 'h2000 && a < 'h2000 + NH * 'h80) begin
      if ((a - 'h2000) % 'h80 < 8) begin
        kind = 3; h = (a - 'h2000) / 'h80; x = ((a - 'h2000) % 'h80) / 4;
      end
    end else if (a >= 'h200000 && a < 'h200000 + NH * 'h1000) begin
      h = (a - 'h200000) / 'h1000;
      if ((a - 'h200000) % 'h1000 == 0) kind = 4;
      else if ((a - 'h200000) % 'h1000 == 4) kind = 5;
    end
  endfunction

  function automatic int best(input int h);
    int bp = m_thr[h];
    int id = 0;
    for (int i = 1; i <= NS; i++) begin
      if (m_pend[i] && m_en[h][i] && m_prio[i] > bp) begin
        bp = m_prio[i];
        id = i;
      end
    end
    return id;
  endfunction

  function automatic logic [31:0] exp_read(input int a);
    int k, h, x;
    logic [31:0] r = '0;
    dec(a, k, h, x);
    case (k)
      1: r = 32'(m_prio[x]);
      2: for (int b = 0; b < 32; b++) if (x * 32 + b <= NS) r[b] = m_pend[x * 32 + b];
      3: for (int b = 0; b < 32; b++) if (x * 32 + b <= NS) r[b] = m_en[h][x * 32 + b];
      4: r = 32'(m_thr[h]);
      5: r = 32'(best(h));
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic model_step();
    int  k, h, x, cl;
    bit  old_isv [0:NS];
    cl = 0;
    old_isv = m_isv;
    if (bus_rd) begin
      dec(int'(bus_addr), k, h, x);
      if (k == 5) cl = best(h);
    end
    if (bus_wr) begin
      dec(int'(bus_addr), k, h, x);
      case (k)
        1: if (x != 0) m_prio[x] = int'(bus_wdata & 32'h7);
        3: for (int b = 0; b < 32; b++)
             if (x * 32 + b >= 1 && x * 32 + b <= NS) m_en[h][x * 32 + b] = bus_wdata[b];
        4: m_thr[h] = int'(bus_wdata & 32'h7);
        5: if (bus_wdata >= 1 && bus_wdata <= NS && m_isv[bus_wdata]) m_isv[bus_wdata] = 1'b0;
        default: ;
      endcase
    end
    for (int i = 1; i <= NS; i++) begin
      if (src_req[i-1] && !old_isv[i]) m_pend[i] = 1'b1;
      if (cl == i) begin m_pend[i] = 1'b0; m_isv[i] = 1'b1; end
    end
  endtask

  // Compare every cycle, shortly before the rising edge, then advance the model
  initial begin
    wait (rst_n);
    forever begin
      @(negedge clk);
      #8;
      for (int h = 0; h < NH; h++) begin
        vectors++;
        if (hart_irq[h] !== (best(h) != 0)) begin
          miscompares++;
          $display("FAIL %s (R7 line) hart %0d: got %0b expected %0b", tag, h,
                   hart_irq[h], best(h) != 0);
        end
      end
      if (bus_rd) begin
        vectors++;
        if (bus_rdata !== exp_read(int'(bus_addr))) begin
          miscompares++;
          $display("FAIL %s read 0x%0h: got 0x%08h expected 0x%08h", tag,
                   bus_addr, bus_rdata, exp_read(int'(bus_addr)));
        end
      end
      @(posedge clk);
      model_step();
    end
  end

  task automatic wr(input int a, input logic [31:0] d, input string t);
    @(negedge clk); #1;
    tag = t; bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
  endtask

  task automatic rd(input int a, input string t);
    @(negedge clk); #1;
    tag = t; bus_addr = AW'(a); bus_wdata = '0; bus_wr = 1'b0; bus_rd = 1'b1;
  endtask

  task automatic idle(input int n, input string t);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      tag = t; bus_wr = 1'b0; bus_rd = 1'b0;
    end
  endtask

  task automatic req(input int id, input bit v);
    src_req[id-1] = v;
  endtask

  localparam int PEND0 = 'h1000;
  localparam int PEND1 = 'h1004;
  function automatic int en_a(input int h, input int w); return 'h2000 + h * 'h80 + w * 4; endfunction
  function automatic int thr_a(input int h); return 'h200000 + h * 'h1000; endfunction
  function automatic int clm_a(input int h); return 'h200004 + h * 'h1000; endfunction

  // Watchdog
  initial begin
    #4000000;
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int i = 0; i <= NS; i++) begin
      m_prio[i] = 0; m_pend[i] = 0; m_isv[i] = 0;
      for (int h = 0; h < NH; h++) m_en[h][i] = 0;
    end
    for (int h = 0; h < NH; h++) m_thr[h] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2, "R1");
    // R1: reset state and the reserved ID
    rd(0, "R1"); rd(PEND0, "R1"); rd(PEND1, "R1"); rd(clm_a(0), "R1");
    rd(clm_a(1), "R1"); rd(en_a(0, 0), "R1");
    // R2: priority storage and zero upper bits
    wr(1 * 4, 32'hFFFF_FFFD, "R2"); wr(53 * 4, 32'h13, "R2"); wr(0, 32'h7, "R1");
    rd(1 * 4, "R2"); rd(53 * 4, "R2"); rd(0, "R1"); rd(54 * 4, "R2");
    // R4: enable words per hart
    wr(en_a(0, 0), 32'hFFFF_FFFF, "R4"); wr(en_a(0, 1), 32'hFFFF_FFFF, "R4");
    wr(en_a(1, 0), 32'h0000_0F00, "R4");
    rd(en_a(0, 0), "R1"); rd(en_a(0, 1), "R4"); rd(en_a(1, 0), "R4"); rd(en_a(1, 1), "R4");
    wr(2 * 4, 5, "R6"); wr(3 * 4, 5, "R6"); wr(9 * 4, 2, "R6"); wr(10 * 4, 0, "R5");
    wr(40 * 4, 7, "R6"); wr(8 * 4, 6, "R6"); wr(33 * 4, 6, "R6"); wr(35 * 4, 6, "R6");
    wr(thr_a(0), 5, "R5"); wr(thr_a(1), 0, "R5");
    // R3: capture and latch of level requests
    req(2, 1); req(3, 1); req(9, 1); req(10, 1);
    idle(1, "R3"); rd(PEND0, "R3");
    req(2, 0); req(3, 0); req(9, 0); req(10, 0);
    idle(1, "R3"); rd(PEND0, "R3"); rd(PEND1, "R3");
    // R5: strict threshold compare, top threshold blocks
    idle(1, "R5"); rd(thr_a(0), "R5");
    wr(thr_a(0), 4, "R5"); idle(1, "R7");
    wr(thr_a(1), 7, "R5"); idle(1, "R5");
    wr(thr_a(1), 1, "R5"); rd(clm_a(1), "R5");
    // R6, R8: claim order with ties, then empty claim
    wr(thr_a(0), 0, "R6");
    rd(clm_a(0), "R6"); rd(clm_a(0), "R6"); rd(clm_a(0), "R8");
    rd(clm_a(0), "R8"); rd(PEND0, "R8");
    // R9: no re-pend while in service, re-arm after completion
    req(2, 1); idle(2, "R9"); rd(PEND0, "R9");
    wr(clm_a(0), 2, "R9"); idle(2, "R9"); rd(PEND0, "R9");
    // R10: ignored completions
    req(3, 1);
    wr(clm_a(0), 0, "R10"); wr(clm_a(0), 60, "R10"); wr(clm_a(0), 67, "R10");
    wr(clm_a(0), 8, "R10"); idle(2, "R10"); rd(PEND0, "R10");
    wr(clm_a(0), 3, "R10"); idle(2, "R10"); rd(PEND0, "R10");
    // R6: ties across the word boundary and the highest level
    req(40, 1); req(33, 1); req(35, 1); req(8, 1); idle(1, "R6");
    req(40, 0); req(33, 0); req(35, 0); req(8, 0);
    rd(PEND1, "R3");
    for (int i = 0; i < 8; i++) rd(clm_a(0), "R6");
    req(2, 0); req(3, 0);
    for (int i = 0; i < 4; i++) rd(clm_a(1), "R8");
    idle(3, "R7");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule